// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss. It walks a two-level page table held in memory for a 32-bit logical address with 1 KB pages. A request carries the logical address and the base address of the outer table. The walker then makes two dependent reads through a memory port whose latency varies. It first reads the outer-table entry. That entry points to a page of the inner table. It then reads the inner-table entry, which holds the physical frame.

When the walk finishes, the block presents a one-cycle response. On success the response holds the physical address. On failure it holds a fault code that names the table level whose entry was marked invalid, together with the logical address that faulted. The walker holds one walk at a time and takes a new request only while idle.

Top module: `ptw_walker`

## Requirements
- R1: After a synchronous reset the walker is idle: `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: The logical address splits into an outer index in bits [31:20], an inner index in bits [19:10] and a page offset in bits [9:0]. The first read of a walk goes to `req_base + 4*outer_index`, wrapping modulo 2^32.
- R3: A table entry is 32 bits wide. Bit 0 is the valid flag and bits [31:10] hold a 22-bit frame number. The second read goes to `(outer_entry[31:10] << 10) + 4*inner_index`, wrapping modulo 2^32. It is issued only after the first read's data has returned with its valid flag set.
- R4: When both entries are valid, the response has `rsp_fault` = 0 and `rsp_paddr` = `{inner_entry[31:10], offset}`.
- R5: When the outer entry's valid flag is 0, the walk ends with `rsp_fault` = 1 and `rsp_level` = 1. No second read is made, and `rsp_fault_addr` equals the request's logical address.
- R6: When the inner entry's valid flag is 0, the walk ends with `rsp_fault` = 1, `rsp_level` = 2, and `rsp_fault_addr` equal to the request's logical address.
- R7: `req_ready` is 1 only while idle. A `req_valid` that arrives while a walk is in progress is ignored: it changes neither the result of the current walk nor the reads it makes.
- R8: Each read raises `mem_req` for exactly one cycle. No further `mem_req` follows until `mem_rvalid` has returned data for it, so the result does not depend on the memory latency.
- R9: `rsp_valid` is high for exactly one cycle per walk, and `req_ready` is 1 in the cycle after it. On success `rsp_level` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_laddr | input | 32 | Logical address to translate |
| req_base | input | 32 | Base address of the outer table |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the table entry to read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | One-cycle walk result strobe |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_level | output | 2 | 0 none, 1 outer level, 2 inner level |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault_addr | output | 32 | Logical address of the walk |

## Verification
The bench targets the extreme indices (all-zero and all-one logical addresses) and a table base near the top of the address space. A walker that widened or truncated the index scaling would read the wrong entry there, or would fail to wrap. Directed faults at each level check the fault level and that an outer fault never issues a second read. A walker that skipped the valid check would return a bogus frame, and one that mislabelled the level would report 2 for 1. Random read latencies, together with requests poked in while the walker is busy, expose two more faults: a walker that re-issues a read or takes a response too early, and a walker that restarts mid-walk. Either one shows up as an extra read or a result for the wrong address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 10;
    localparam int LO_W     = 10;
    localparam int HI_W     = VA_W - OFF_W - LO_W;
    localparam int PTE_W    = 32;
    localparam int FRAME_W  = PTE_W - OFF_W;
    localparam int ESZ_LOG2 = 2;
    localparam int RSVD_W   = PTE_W - FRAME_W - 1;

    typedef enum logic [2:0] {
        W_IDLE,
        W_RD_OUTER,
        W_RD_INNER,
        W_DONE,
        W_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        LVL_NONE  = 2'd0,
        LVL_OUTER = 2'd1,
        LVL_INNER = 2'd2
    } fault_lvl_e;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
        logic [OFF_W-1:0] off;
    } va_fields_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSVD_W-1:0]  rsvd;
        logic               valid;
    } pte_t;

    function automatic logic [VA_W-1:0] scale_hi(logic [HI_W-1:0] idx);
        return {{(VA_W-HI_W-ESZ_LOG2){1'b0}}, idx, {ESZ_LOG2{1'b0}}};
    endfunction

    function automatic logic [VA_W-1:0] scale_lo(logic [LO_W-1:0] idx);
        return {{(VA_W-LO_W-ESZ_LOG2){1'b0}}, idx, {ESZ_LOG2{1'b0}}};
    endfunction

    function automatic logic [VA_W-1:0] frame_base(logic [FRAME_W-1:0] f);
        return {f, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_rvalid,
    input  logic        rd_entry_ok,
    output walk_state_e state,
    output logic        req_ready,
    output logic        mem_req,
    output logic        accept,
    output logic        cap_outer,
    output logic        cap_inner,
    output fault_lvl_e  lvl
);
    walk_state_e state_q, state_d;
    fault_lvl_e  lvl_q;
    logic        issued_q;
    logic        got;
    logic        in_read;

    assign state     = state_q;
    assign lvl       = lvl_q;
    assign in_read   = (state_q == W_RD_OUTER) || (state_q == W_RD_INNER);
    assign got       = issued_q && mem_rvalid;
    assign req_ready = (state_q == W_IDLE);
    assign accept    = req_ready && req_valid;
    assign mem_req   = in_read && !issued_q;
    assign cap_outer = (state_q == W_RD_OUTER) && got && rd_entry_ok;
    assign cap_inner = (state_q == W_RD_INNER) && got && rd_entry_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:     if (req_valid) state_d = W_RD_OUTER;
            W_RD_OUTER: if (got) state_d = rd_entry_ok ? W_RD_INNER : W_FAULT;
            W_RD_INNER: if (got) state_d = rd_entry_ok ? W_DONE : W_FAULT;
            W_DONE:     state_d = W_IDLE;
            W_FAULT:    state_d = W_IDLE;
            default:    state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= W_IDLE;
            issued_q <= 1'b0;
            lvl_q    <= LVL_NONE;
        end else begin
            state_q  <= state_d;
            issued_q <= (state_d == state_q) ? (issued_q | mem_req) : 1'b0;
            if (accept)
                lvl_q <= LVL_NONE;
            else if (state_d == W_FAULT && state_q != W_FAULT)
                lvl_q <= (state_q == W_RD_OUTER) ? LVL_OUTER : LVL_INNER;
        end
    end

    // R8
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R8
    req_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> in_read);

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == W_DONE || state_q == W_FAULT) |=> req_ready);

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  walk_state_e         state,
    input  va_fields_t          va,
    input  logic [VA_W-1:0]     outer_base,
    input  logic [FRAME_W-1:0]  inner_ptr,
    output logic [VA_W-1:0]     mem_addr
);
    logic [VA_W-1:0] outer_addr;
    logic [VA_W-1:0] inner_addr;

    assign outer_addr = outer_base + scale_hi(va.hi);
    assign inner_addr = frame_base(inner_ptr) + scale_lo(va.lo);
    assign mem_addr   = (state == W_RD_INNER) ? inner_addr : outer_addr;

endmodule

// File: rtl/ptw_regs.sv
module ptw_regs
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [VA_W-1:0]    req_laddr,
    input  logic [VA_W-1:0]    req_base,
    input  logic               cap_outer,
    input  logic               cap_inner,
    input  pte_t               rd_entry,
    input  walk_state_e        state,
    input  fault_lvl_e         lvl,
    output va_fields_t         va,
    output logic [VA_W-1:0]    outer_base,
    output logic [FRAME_W-1:0] inner_ptr,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_level,
    output logic [VA_W-1:0]    rsp_paddr,
    output logic [VA_W-1:0]    rsp_fault_addr
);
    logic [VA_W-1:0]    laddr_q;
    logic [VA_W-1:0]    base_q;
    logic [FRAME_W-1:0] ptr_q;
    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            laddr_q <= '0;
            base_q  <= '0;
            ptr_q   <= '0;
            frame_q <= '0;
        end else begin
            if (accept) begin
                laddr_q <= req_laddr;
                base_q  <= req_base;
            end
            if (cap_outer) ptr_q   <= rd_entry.frame;
            if (cap_inner) frame_q <= rd_entry.frame;
        end
    end

    assign va             = va_fields_t'(laddr_q);
    assign outer_base     = base_q;
    assign inner_ptr      = ptr_q;
    assign rsp_valid      = (state == W_DONE) || (state == W_FAULT);
    assign rsp_fault      = (state == W_FAULT);
    assign rsp_level      = lvl;
    assign rsp_paddr      = (state == W_DONE) ? {frame_q, va.off} : '0;
    assign rsp_fault_addr = laddr_q;

    // R5
    fault_level_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_level != 2'd0)));

    // R7
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(laddr_q));

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_laddr,
    input  logic [31:0] req_base,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [1:0]  rsp_level,
    output logic [31:0] rsp_paddr,
    output logic [31:0] rsp_fault_addr
);
    walk_state_e        state;
    fault_lvl_e         lvl;
    logic               accept;
    logic               cap_outer;
    logic               cap_inner;
    pte_t               rd_entry;
    va_fields_t         va;
    logic [VA_W-1:0]    outer_base;
    logic [FRAME_W-1:0] inner_ptr;

    assign rd_entry = pte_t'(mem_rdata);

    ptw_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .mem_rvalid  (mem_rvalid),
        .rd_entry_ok (rd_entry.valid),
        .state       (state),
        .req_ready   (req_ready),
        .mem_req     (mem_req),
        .accept      (accept),
        .cap_outer   (cap_outer),
        .cap_inner   (cap_inner),
        .lvl         (lvl)
    );

    ptw_addr_gen u_agen (
        .state      (state),
        .va         (va),
        .outer_base (outer_base),
        .inner_ptr  (inner_ptr),
        .mem_addr   (mem_addr)
    );

    ptw_regs u_regs (
        .clk            (clk),
        .rst            (rst),
        .accept         (accept),
        .req_laddr      (req_laddr),
        .req_base       (req_base),
        .cap_outer      (cap_outer),
        .cap_inner      (cap_inner),
        .rd_entry       (rd_entry),
        .state          (state),
        .lvl            (lvl),
        .va             (va),
        .outer_base     (outer_base),
        .inner_ptr      (inner_ptr),
        .rsp_valid      (rsp_valid),
        .rsp_fault      (rsp_fault),
        .rsp_level      (rsp_level),
        .rsp_paddr      (rsp_paddr),
        .rsp_fault_addr (rsp_fault_addr)
    );

    // R3
    inner_after_outer_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && state == W_RD_INNER) |-> $past(state) != W_IDLE);

endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic [31:0] req_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_level;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_fault_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // memory model state
    int          mode = 0;      // 0 hash, 1 outer invalid, 2 inner invalid, 3 all valid
    int          ord = 0;
    int          lat = 1;
    bit          pending = 0;
    int          cnt = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] seen_addr [2];

    always #2.5 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .req_base(req_base), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
        .rsp_paddr(rsp_paddr), .rsp_fault_addr(rsp_fault_addr)
    );

    function automatic logic [31:0] entry_of(logic [31:0] a, int o, int m);
        logic [31:0] h;
        logic v;
        h = (a ^ (a >> 7)) * 32'h9E3779B1;
        case (m)
            1: v = (o == 0) ? 1'b0 : 1'b1;
            2: v = (o == 0) ? 1'b1 : 1'b0;
            3: v = 1'b1;
            default: v = (h[3:0] >= 4'd2);
        endcase
        return {h[31:10], 9'b0, v};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mem_rvalid) mem_rvalid <= 1'b0;
        if (mem_req) begin
            if (ord < 2) seen_addr[ord] = mem_addr;
            pend_addr = mem_addr;
            pending = 1;
            cnt = lat;
            ord++;
        end else if (pending) begin
            cnt--;
            if (cnt <= 0) begin
                pending = 0;
                mem_rvalid <= 1'b1;
                mem_rdata  <= entry_of(pend_addr, ord - 1, mode);
            end
        end
    end

    task automatic walk(logic [31:0] la, logic [31:0] base, int m, bit poke);
        logic [31:0] a1, a2, e1, e2, exp_pa;
        int exp_reads, exp_lvl;
        bit got;
        mode = m;
        ord = 0;
        lat = 1 + int'($urandom % 4);
        a1 = base + {18'b0, la[31:20], 2'b0};
        e1 = entry_of(a1, 0, m);
        a2 = {e1[31:10], 10'b0} + {20'b0, la[19:10], 2'b0};
        e2 = entry_of(a2, 1, m);
        if (!e1[0]) begin exp_reads = 1; exp_lvl = 1; end
        else if (!e2[0]) begin exp_reads = 2; exp_lvl = 2; end
        else begin exp_reads = 2; exp_lvl = 0; end
        exp_pa = (exp_lvl == 0) ? {e2[31:10], la[9:0]} : 32'h0;

        @(negedge clk);
        req_laddr = la; req_base = base; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R7: request while busy must be refused
            check(req_ready == 1'b0, "R7", "ready while busy", {31'b0, req_ready}, 32'h0);
            req_laddr = ~la; req_base = base ^ 32'h55AA_0000; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        got = 0;
        for (int i = 0; i < 100 && !got; i++) begin
            if (rsp_valid) got = 1;
            else @(negedge clk);
        end
        check(got, "R8", "response arrived", {31'b0, got}, 32'h1);
        if (got) begin
            check(rsp_fault == (exp_lvl != 0), exp_lvl == 1 ? "R5" : (exp_lvl == 2 ? "R6" : "R4"),
                  "fault flag", {31'b0, rsp_fault}, {31'b0, exp_lvl != 0});
            check(rsp_level == 2'(exp_lvl), exp_lvl == 0 ? "R9" : "R5/R6 level", "level",
                  {30'b0, rsp_level}, exp_lvl);
            check(seen_addr[0] == a1, "R2", "outer read address", seen_addr[0], a1);
            if (exp_lvl == 0)
                check(rsp_paddr == exp_pa, "R4", "physical address", rsp_paddr, exp_pa);
            else
                check(rsp_fault_addr == la, exp_lvl == 1 ? "R5" : "R6", "fault address", rsp_fault_addr, la);
            if (exp_reads == 2)
                check(seen_addr[1] == a2, "R3", "inner read address", seen_addr[1], a2);
            @(negedge clk);
            check(!rsp_valid && req_ready, "R9", "one-cycle response then ready",
                  {30'b0, rsp_valid, req_ready}, 32'h1);
            repeat (2) @(negedge clk);
            check(ord == exp_reads, exp_lvl == 1 ? "R5" : "R8", "read count", ord, exp_reads);
        end
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        // R1
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R1", "reset state",
              {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && mem_req == 1'b0, "R1", "idle after reset",
              {30'b0, req_ready, mem_req}, 32'h2);

        walk(32'h0000_0000, 32'h0001_0000, 3, 0);
        walk(32'hFFFF_FFFF, 32'h0002_0000, 3, 0);
        walk(32'h8040_13FF, 32'hFFFF_F000, 3, 0);
        walk(32'h1234_5678, 32'h0003_0000, 1, 0);
        walk(32'hFFF0_0000, 32'h0004_0000, 2, 0);
        walk(32'hABCD_EF01, 32'h0005_0000, 3, 1);
        walk(32'h0010_0400, 32'h0006_0000, 1, 1);

        for (int n = 0; n < 200; n++) begin
            int r;
            int m;
            r = int'($urandom % 8);
            m = (r < 5) ? 0 : (r == 5 ? 3 : (r == 6 ? 1 : 2));
            walk($urandom, {$urandom} & 32'hFFFF_FFFC, m, ($urandom % 5) == 0);
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule